// File: doc/BRIEF.md
# Synchronous Pipelined Burst SRAM

This block is a synthesizable model of a single-clock synchronous SRAM with a parameterizable word depth and four byte lanes. Every address, write control, chip-select and burst control is captured on the rising clock edge. A burst is opened by one of two address strobes. A two-bit counter then walks the low address bits through a four-word block, in either linear or interleaved order.

Reads go through a two-stage pipeline, and an asynchronous output enable gates the read port. Writes store selected byte lanes or the whole word in the cycle the command is taken. The read port stays valid for one extra cycle after a deselect that follows a read, which gives double-cycle deselect. The data path is split into a write bus and a read bus with a valid flag; no bidirectional pad is modelled.

Top module: `sync_burst_sram`

## Requirements
- R1: A read taken at rising edge E shows its word on `rdata` with `rdata_vld` high after edge E+1. Back-to-back reads deliver one word per cycle.
- R2: With `burst_linear`=1, the low two address bits of burst beat k equal (start offset + k) mod 4.
- R3: With `burst_linear`=0, the low two address bits of burst beat k equal start offset XOR k.
- R4: A burst wraps inside its aligned four-word block, and address bits above bit 1 never change during a burst.
- R5: On a cycle with no accepted strobe during an open burst, the counter steps only when `advance_n` is low. With `advance_n` high, the same address is accessed again.
- R6: `strobe_cpu_n` low with `csel_n` low loads a new base, and that cycle is a read whatever the write controls say. `strobe_cpu_n` low while `csel_n` is high is ignored.
- R7: `strobe_ctl_n` low loads a new base, even in the middle of a burst. While the part is selected, that cycle writes when `wr_all_n` is low or any `wr_lane_n` bit is low, and reads otherwise.
- R8: The part is selected only when `csel_n`=0, `csel_hi`=1 and `csel_lo_n`=0. An accepted strobe while unselected closes the burst and neither reads nor writes.
- R9: In a write with `wr_all_n` high, `wr_lane_n[i]` low stores bits 8i+7..8i and the other lanes keep their contents. With `wr_all_n` low, all four lanes are stored.
- R10: When the cycle after a read is a deselect, the read word stays on `rdata` with `rdata_vld` high for one extra cycle. When the cycle after a read is a write, `rdata_vld` drops after one cycle.
- R11: While `out_en_n` is high, `rdata_vld` is 0 and `rdata` is 0 in the same cycle, with no clock edge needed.
- R12: Reset clears the read port and closes any open burst, so continue cycles after reset neither read nor write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr_i | input | ADDR_W | Word address taken by a strobe |
| strobe_cpu_n | input | 1 | Read-only burst start strobe, active low, needs `csel_n` low |
| strobe_ctl_n | input | 1 | Read or write burst start strobe, active low |
| advance_n | input | 1 | Burst counter step enable, active low |
| csel_n | input | 1 | Primary chip select, active low |
| csel_hi | input | 1 | Expansion chip select, active high |
| csel_lo_n | input | 1 | Expansion chip select, active low |
| burst_linear | input | 1 | 1 for linear order, 0 for interleaved order |
| wr_all_n | input | 1 | Whole-word write, active low |
| wr_lane_n | input | LANES | Per-lane write enables, active low |
| wdata | input | LANES*LANE_W | Write data |
| out_en_n | input | 1 | Asynchronous read port enable, active low |
| rdata | output | LANES*LANE_W | Read data, 0 when not valid |
| rdata_vld | output | 1 | Read data valid |

## Verification
The hardest state to reach from the ports is a double-cycle-deselect hold that must be told apart from ordinary pipeline flow. The extra valid cycle appears only when the cycle right after a read is an unselected cycle, and it must be absent when that cycle is a write. The bench builds both sequences back to back from the same read: a strobe-opened read followed by an unselected strobe, and a read followed by a mid-burst write strobe. It samples the read port on each of the next three cycles. Suspend behaviour is reached by sending an ignored read strobe, with the primary select high and a different address, in the middle of an open burst.

// File: rtl/bsram_pkg.sv
package bsram_pkg;

    typedef enum logic [1:0] {
        OP_IDLE = 2'd0,
        OP_RD   = 2'd1,
        OP_WR   = 2'd2
    } op_e;

    localparam int OFS_W = 2;

    // Low address bits of a burst beat: linear adds the step, interleaved xors it.
    function automatic logic [OFS_W-1:0] burst_offset(
        input logic [OFS_W-1:0] start,
        input logic [OFS_W-1:0] step,
        input logic             linear
    );
        return linear ? (start + step) : (start ^ step);
    endfunction

endpackage

// File: rtl/bsram_burst_ctrl.sv
module bsram_burst_ctrl
    import bsram_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int LANES  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              strobe_cpu_n,
    input  logic              strobe_ctl_n,
    input  logic              advance_n,
    input  logic              csel_n,
    input  logic              csel_hi,
    input  logic              csel_lo_n,
    input  logic              burst_linear,
    input  logic              wr_all_n,
    input  logic [LANES-1:0]  wr_lane_n,
    output op_e               op_o,
    output logic [ADDR_W-1:0] acc_addr_o,
    output logic [LANES-1:0]  lane_we_o
);

    localparam int HI_W = ADDR_W - OFS_W;

    typedef struct packed {
        logic [ADDR_W-1:0] base;
        logic [OFS_W-1:0]  cnt;
        logic              active;
    } st_t;

    st_t  st_d, st_q;
    logic selected;
    logic wr_req;
    logic cpu_start;
    logic ctl_start;
    logic load;

    always_comb begin
        st_d      = st_q;
        op_o      = OP_IDLE;
        selected  = !csel_n && csel_hi && !csel_lo_n;
        wr_req    = !wr_all_n || !(&wr_lane_n);
        cpu_start = !strobe_cpu_n && !csel_n;
        ctl_start = !strobe_ctl_n && !cpu_start;
        load      = cpu_start || ctl_start;
        if (load) begin
            st_d.base   = addr_i;
            st_d.cnt    = '0;
            st_d.active = selected;
            if (selected) begin
                op_o = (cpu_start || !wr_req) ? OP_RD : OP_WR;
            end
        end else if (st_q.active) begin
            if (!advance_n) begin
                st_d.cnt = st_q.cnt + OFS_W'(1);
            end
            op_o = wr_req ? OP_WR : OP_RD;
        end
        acc_addr_o = {st_d.base[ADDR_W-1:OFS_W],
                      burst_offset(st_d.base[OFS_W-1:0], st_d.cnt, burst_linear)};
        lane_we_o  = wr_all_n ? ~wr_lane_n : '1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // R5: suspend cycle keeps the burst counter
    assert_cnt_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.active && strobe_cpu_n && strobe_ctl_n && advance_n) |=> $stable(st_q.cnt));

    // R4: without a strobe the block base (and its upper bits) stays put
    assert_upper_stable_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe_cpu_n && strobe_ctl_n) |=> ($past(acc_addr_o[ADDR_W-1:OFS_W]) == st_q.base[ADDR_W-1:OFS_W] || !$past(st_q.active)));

    // R12: an unopened burst issues no access without a strobe
    assert_idle_no_op_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_q.active && strobe_cpu_n && strobe_ctl_n) |-> (op_o == OP_IDLE));

    logic unused_hi;
    assign unused_hi = ^HI_W;

endmodule

// File: rtl/bsram_array.sv
module bsram_array
    import bsram_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int LANES  = 4,
    parameter int LANE_W = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  op_e                     op_i,
    input  logic [ADDR_W-1:0]       addr_i,
    input  logic [LANES-1:0]        lane_we_i,
    input  logic [LANES*LANE_W-1:0] wdata_i,
    output op_e                     op_o,
    output logic [LANES*LANE_W-1:0] rd_o
);

    localparam int DATA_W = LANES * LANE_W;
    localparam int DEPTH  = 1 << ADDR_W;

    typedef struct packed {
        op_e               op;
        logic [DATA_W-1:0] rd;
    } stg_t;

    logic [DATA_W-1:0] mem [DEPTH];
    logic [DATA_W-1:0] bit_we;
    logic [DATA_W-1:0] merged;
    stg_t              stg_d, stg_q;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign bit_we[g*LANE_W +: LANE_W] = {LANE_W{lane_we_i[g]}};
    end

    always_comb begin
        merged    = (mem[addr_i] & ~bit_we) | (wdata_i & bit_we);
        stg_d     = stg_q;
        stg_d.op  = op_i;
        if (op_i == OP_RD) begin
            stg_d.rd = mem[addr_i];
        end
    end

    always_ff @(posedge clk) begin
        if (op_i == OP_WR) begin
            mem[addr_i] <= merged;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stg_q <= '{op: OP_IDLE, rd: '0};
        end else begin
            stg_q <= stg_d;
        end
    end

    assign op_o = stg_q.op;
    assign rd_o = stg_q.rd;

    // R1: a non-read cycle leaves the read register untouched
    assert_rd_keep_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i != OP_RD) |=> $stable(rd_o));

endmodule

// File: rtl/bsram_out_stage.sv
module bsram_out_stage
    import bsram_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  op_e               op_i,
    input  logic [DATA_W-1:0] rd_i,
    input  logic              out_en_n,
    output logic [DATA_W-1:0] rdata,
    output logic              rdata_vld,
    output logic              held_vld_o
);

    typedef struct packed {
        logic [DATA_W-1:0] data;
        logic              vld;
        logic              ext;
    } out_t;

    out_t os_d, os_q;

    always_comb begin
        os_d = os_q;
        unique case (op_i)
            OP_RD: begin
                os_d.data = rd_i;
                os_d.vld  = 1'b1;
                os_d.ext  = 1'b0;
            end
            OP_IDLE: begin
                os_d.vld = os_q.vld && !os_q.ext;
                os_d.ext = os_q.vld && !os_q.ext;
            end
            default: begin
                os_d.vld = 1'b0;
                os_d.ext = 1'b0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            os_q <= '0;
        end else begin
            os_q <= os_d;
        end
    end

    assign rdata_vld  = os_q.vld && !out_en_n;
    assign rdata      = rdata_vld ? os_q.data : '0;
    assign held_vld_o = os_q.vld;

    // R10: a deselect right after a read keeps the word one more cycle
    assert_dcd_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == OP_IDLE && os_q.vld && !os_q.ext) |=> (os_q.vld && $stable(os_q.data)));

    // R10: the extension lasts a single cycle
    assert_ext_once_R10: assert property (@(posedge clk) disable iff (!rst_n)
        os_q.ext |=> !os_q.ext);

    // R10: a write cycle ends the valid window
    assert_wr_drop_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == OP_WR) |=> !os_q.vld);

endmodule

// File: rtl/sync_burst_sram.sv
module sync_burst_sram
    import bsram_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int LANES  = 4,
    parameter int LANE_W = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [ADDR_W-1:0]       addr_i,
    input  logic                    strobe_cpu_n,
    input  logic                    strobe_ctl_n,
    input  logic                    advance_n,
    input  logic                    csel_n,
    input  logic                    csel_hi,
    input  logic                    csel_lo_n,
    input  logic                    burst_linear,
    input  logic                    wr_all_n,
    input  logic [LANES-1:0]        wr_lane_n,
    input  logic [LANES*LANE_W-1:0] wdata,
    input  logic                    out_en_n,
    output logic [LANES*LANE_W-1:0] rdata,
    output logic                    rdata_vld
);

    localparam int DATA_W = LANES * LANE_W;

    op_e               acc_op;
    logic [ADDR_W-1:0] acc_addr;
    logic [LANES-1:0]  lane_we;
    op_e               stg_op;
    logic [DATA_W-1:0] stg_rd;
    logic              held_vld;

    bsram_burst_ctrl #(.ADDR_W(ADDR_W), .LANES(LANES)) u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .addr_i       (addr_i),
        .strobe_cpu_n (strobe_cpu_n),
        .strobe_ctl_n (strobe_ctl_n),
        .advance_n    (advance_n),
        .csel_n       (csel_n),
        .csel_hi      (csel_hi),
        .csel_lo_n    (csel_lo_n),
        .burst_linear (burst_linear),
        .wr_all_n     (wr_all_n),
        .wr_lane_n    (wr_lane_n),
        .op_o         (acc_op),
        .acc_addr_o   (acc_addr),
        .lane_we_o    (lane_we)
    );

    bsram_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_array (
        .clk       (clk),
        .rst_n     (rst_n),
        .op_i      (acc_op),
        .addr_i    (acc_addr),
        .lane_we_i (lane_we),
        .wdata_i   (wdata),
        .op_o      (stg_op),
        .rd_o      (stg_rd)
    );

    bsram_out_stage #(.DATA_W(DATA_W)) u_out (
        .clk        (clk),
        .rst_n      (rst_n),
        .op_i       (stg_op),
        .rd_i       (stg_rd),
        .out_en_n   (out_en_n),
        .rdata      (rdata),
        .rdata_vld  (rdata_vld),
        .held_vld_o (held_vld)
    );

    // R1: read issued now is valid on the port two edges later
    assert_read_lat_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_op == OP_RD) |=> ##1 held_vld);

    // R6: the read-only strobe never produces a write
    assert_cpu_strobe_read_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!strobe_cpu_n && !csel_n) |-> (acc_op != OP_WR));

    // R8: a strobe while unselected performs no access
    assert_unsel_no_access_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!(!csel_n && csel_hi && !csel_lo_n) && (!strobe_ctl_n || (!strobe_cpu_n && !csel_n)))
        |-> (acc_op == OP_IDLE));

    // R11: disabled read port never signals valid data
    always_comb begin
        if (rst_n && out_en_n) begin
            assert_oe_gate_R11: assert (!rdata_vld && rdata == '0);
        end
    end

endmodule

// File: tb/tb_sync_burst_sram.sv
module tb_sync_burst_sram;

    localparam int AW = 6;
    localparam int DW = 32;

    logic          clk = 1'b0;
    logic          rst_n;
    logic [AW-1:0] addr_i;
    logic          strobe_cpu_n, strobe_ctl_n, advance_n;
    logic          csel_n, csel_hi, csel_lo_n, burst_linear;
    logic          wr_all_n;
    logic [3:0]    wr_lane_n;
    logic [DW-1:0] wdata;
    logic          out_en_n;
    logic [DW-1:0] rdata;
    logic          rdata_vld;

    logic [DW-1:0] model_mem [1 << AW];
    int            checks = 0;
    int            errors = 0;
    bit            done   = 1'b0;

    sync_burst_sram #(.ADDR_W(AW), .LANES(4), .LANE_W(8)) dut (
        .clk(clk), .rst_n(rst_n), .addr_i(addr_i),
        .strobe_cpu_n(strobe_cpu_n), .strobe_ctl_n(strobe_ctl_n), .advance_n(advance_n),
        .csel_n(csel_n), .csel_hi(csel_hi), .csel_lo_n(csel_lo_n),
        .burst_linear(burst_linear), .wr_all_n(wr_all_n), .wr_lane_n(wr_lane_n),
        .wdata(wdata), .out_en_n(out_en_n), .rdata(rdata), .rdata_vld(rdata_vld)
    );

    always #10 clk = ~clk;

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input string req, input bit ev, input logic [DW-1:0] ed);
        checks++;
        if (rdata_vld !== ev || (ev && rdata !== ed) || (!ev && rdata !== '0)) begin
            errors++;
            $display("FAIL %s: vld=%0b data=%h expected vld=%0b data=%h",
                     req, rdata_vld, rdata, ev, ed);
        end
    endtask

    function automatic logic [AW-1:0] baddr(input logic [AW-1:0] base, input int k, input bit lin);
        logic [1:0] s;
        s = 2'(k);
        return {base[AW-1:2], lin ? base[1:0] + s : base[1:0] ^ s};
    endfunction

    task automatic drv_idle();
        strobe_cpu_n = 1'b1; strobe_ctl_n = 1'b1; advance_n = 1'b1;
        csel_n = 1'b1; csel_hi = 1'b0; csel_lo_n = 1'b1;
        wr_all_n = 1'b1; wr_lane_n = 4'hF; wdata = '0; addr_i = '0;
    endtask

    task automatic sel_on();
        csel_n = 1'b0; csel_hi = 1'b1; csel_lo_n = 1'b0;
    endtask

    task automatic drv_desel();
        strobe_cpu_n = 1'b1; strobe_ctl_n = 1'b0; advance_n = 1'b1;
        csel_n = 1'b0; csel_hi = 1'b0; csel_lo_n = 1'b0;
        wr_all_n = 1'b1; wr_lane_n = 4'hF;
    endtask

    task automatic model_write(input logic [AW-1:0] a, input bit all_n,
                               input logic [3:0] ln, input logic [DW-1:0] d);
        for (int i = 0; i < 4; i++) begin
            if (!all_n || !ln[i]) model_mem[a][i*8 +: 8] = d[i*8 +: 8];
        end
    endtask

    task automatic write_burst(input logic [AW-1:0] base, input bit lin, input bit all_n,
                               input logic [3:0] ln, input logic [DW-1:0] seed);
        for (int i = 0; i < 4; i++) begin
            strobe_cpu_n = 1'b1;
            strobe_ctl_n = (i == 0) ? 1'b0 : 1'b1;
            advance_n    = (i == 0) ? 1'b1 : 1'b0;
            addr_i = base; sel_on();
            burst_linear = lin; wr_all_n = all_n; wr_lane_n = ln;
            wdata = seed ^ (32'h0101_0101 * i);
            model_write(baddr(base, i, lin), all_n, ln, wdata);
            tick();
        end
        drv_desel(); tick();
        drv_idle(); tick();
    endtask

    task automatic read_burst(input logic [AW-1:0] base, input bit lin, input string req);
        for (int i = 0; i < 4; i++) begin
            strobe_ctl_n = 1'b1;
            strobe_cpu_n = (i == 0) ? 1'b0 : 1'b1;
            advance_n    = (i == 0) ? 1'b1 : 1'b0;
            addr_i = base; sel_on(); burst_linear = lin;
            wr_all_n = 1'b1; wr_lane_n = 4'hF;
            tick();
            if (i > 0) chk(req, 1'b1, model_mem[baddr(base, i - 1, lin)]);
        end
        drv_desel(); tick();
        chk(req, 1'b1, model_mem[baddr(base, 3, lin)]);
        drv_idle(); tick();
        chk("R10 hold", 1'b1, model_mem[baddr(base, 3, lin)]);
        tick();
        chk("R10 end", 1'b0, '0);
    endtask

    task automatic test_orders();
        write_burst(6'h0E, 1'b1, 1'b0, 4'hF, 32'h5A00_1100);
        read_burst(6'h0E, 1'b1, "R2 linear");
        read_burst(6'h17, 1'b1, "R4 wrap");
        write_burst(6'h21, 1'b0, 1'b0, 4'hF, 32'h3C00_2200);
        read_burst(6'h21, 1'b0, "R3 interleaved");
        read_burst(6'h2A, 1'b0, "R3 interleaved");
    endtask

    task automatic single_write(input logic [AW-1:0] a, input bit all_n,
                                input logic [3:0] ln, input logic [DW-1:0] d);
        strobe_ctl_n = 1'b0; strobe_cpu_n = 1'b1; advance_n = 1'b1;
        addr_i = a; sel_on(); wr_all_n = all_n; wr_lane_n = ln; wdata = d;
        model_write(a, all_n, ln, d);
        tick();
        drv_desel(); tick();
        drv_idle(); tick();
    endtask

    task automatic test_lanes();
        single_write(6'h30, 1'b1, 4'b1010, 32'hDEAD_BEEF);
        single_write(6'h31, 1'b1, 4'b0111, 32'h1234_5678);
        single_write(6'h32, 1'b0, 4'hF, 32'hCAFE_F00D);
        read_burst(6'h30, 1'b1, "R9 lanes");
    endtask

    task automatic test_suspend();
        strobe_cpu_n = 1'b0; strobe_ctl_n = 1'b1; advance_n = 1'b1;
        addr_i = 6'h08; sel_on(); burst_linear = 1'b1;
        wr_all_n = 1'b0; wdata = 32'hFFFF_FFFF;
        tick();
        strobe_cpu_n = 1'b0; csel_n = 1'b1; addr_i = 6'h3C;
        wr_all_n = 1'b1;
        tick();
        chk("R6 read-only start", 1'b1, model_mem[6'h08]);
        strobe_cpu_n = 1'b1; csel_n = 1'b0; advance_n = 1'b0;
        tick();
        chk("R5 suspend same address", 1'b1, model_mem[6'h08]);
        drv_desel(); tick();
        chk("R5 step after advance", 1'b1, model_mem[6'h09]);
        drv_idle(); tick();
        chk("R10 hold", 1'b1, model_mem[6'h09]);
        tick();
        chk("R10 end", 1'b0, '0);
        read_burst(6'h08, 1'b1, "R6 no write");
    endtask

    task automatic test_unselected();
        strobe_ctl_n = 1'b0; strobe_cpu_n = 1'b1; addr_i = 6'h10; sel_on();
        csel_lo_n = 1'b1; wr_all_n = 1'b0; wdata = '0;
        tick();
        strobe_ctl_n = 1'b1; strobe_cpu_n = 1'b0; sel_on(); csel_hi = 1'b0;
        wr_all_n = 1'b1;
        tick();
        chk("R8 no read", 1'b0, '0);
        strobe_ctl_n = 1'b0; strobe_cpu_n = 1'b1; addr_i = 6'h11; csel_n = 1'b1;
        csel_hi = 1'b1; wr_all_n = 1'b0;
        tick();
        chk("R8 no read", 1'b0, '0);
        drv_idle(); tick(); tick();
        chk("R8 idle", 1'b0, '0);
        read_burst(6'h10, 1'b1, "R8 no write");
    endtask

    task automatic test_read_then_write();
        strobe_cpu_n = 1'b0; strobe_ctl_n = 1'b1; advance_n = 1'b1;
        addr_i = 6'h05; sel_on(); burst_linear = 1'b1; wr_all_n = 1'b1; wr_lane_n = 4'hF;
        tick();
        strobe_cpu_n = 1'b1; strobe_ctl_n = 1'b0; addr_i = 6'h3A;
        wr_all_n = 1'b0; wdata = 32'h8765_4321;
        model_write(6'h3A, 1'b0, 4'hF, wdata);
        tick();
        chk("R10 read word", 1'b1, model_mem[6'h05]);
        drv_desel(); tick();
        chk("R10 drop on write", 1'b0, '0);
        drv_idle(); tick();
        chk("R10 stays low", 1'b0, '0);
        read_burst(6'h3A, 1'b1, "R7 mid-burst write");
    endtask

    task automatic test_oe();
        strobe_cpu_n = 1'b0; strobe_ctl_n = 1'b1; advance_n = 1'b1;
        addr_i = 6'h20; sel_on(); wr_all_n = 1'b1; wr_lane_n = 4'hF;
        tick();
        drv_desel(); tick();
        chk("R1 latency", 1'b1, model_mem[6'h20]);
        out_en_n = 1'b1; #1;
        chk("R11 gated", 1'b0, '0);
        out_en_n = 1'b0; #1;
        chk("R11 released", 1'b1, model_mem[6'h20]);
        drv_idle(); tick();
        chk("R10 hold", 1'b1, model_mem[6'h20]);
        tick();
    endtask

    task automatic test_reset();
        strobe_cpu_n = 1'b1; strobe_ctl_n = 1'b0; advance_n = 1'b1;
        addr_i = 6'h1C; sel_on(); wr_all_n = 1'b1; wr_lane_n = 4'hF;
        tick();
        rst_n = 1'b0; strobe_ctl_n = 1'b1;
        tick();
        chk("R12 cleared", 1'b0, '0);
        rst_n = 1'b1;
        advance_n = 1'b0; wr_all_n = 1'b0; wdata = '0;
        tick(); tick();
        chk("R12 no read", 1'b0, '0);
        drv_idle(); tick();
        read_burst(6'h1C, 1'b1, "R12 no write");
    endtask

    initial begin
        rst_n = 1'b0; out_en_n = 1'b0; burst_linear = 1'b1;
        drv_idle();
        repeat (3) tick();
        chk("R12 reset", 1'b0, '0);
        rst_n = 1'b1;
        tick();
        for (int b = 0; b < 16; b++) begin
            write_burst(6'(b * 4), 1'b1, 1'b0, 4'hF, 32'hA500_0000 + 32'(b) * 32'h0004_0C01);
        end
        read_burst(6'h00, 1'b1, "R1 stream");
        test_orders();
        test_lanes();
        test_suspend();
        test_unselected();
        test_read_then_write();
        test_oe();
        test_reset();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule